// File: doc/BRIEF.md
# Split-Term Product Register with Mode-Selected Multiplier

This block multiplies two 16-bit operands and keeps the result in a 40-bit product. The product is stored as four partial registers rather than as one word: a 16-bit low term, a 16-bit middle term, an 8-bit top term and a second 16-bit middle term. The value the block reports is rebuilt from these parts. The two middle terms are added together, so the pair is a redundant form of bits 31:16. Carries out of that addition move into the top byte.

Signedness is not set by a separate control. It follows from which half of a source register each operand was taken from. Two half-select inputs report this. A low half is always treated as unsigned, and a high half is always treated as signed. The block also accepts two other operations. A clear writes a non-zero preset pattern whose parts sum to zero. A full-value load writes all 40 bits directly. The rebuilt product appears on a registered output, together with the four raw partial registers, so a consumer can read either form.

Top module: `split_prod_mul`

## Requirements
- R1: While reset is asserted, and right after it is released, the partial registers hold low=0x0000, mid=0xfff0, top=0xff and second mid=0x0010, and the combined output reads 0.
- R2: An accepted operation with code 2'b01 (clear) writes the same preset as R1. After the accepting edge the combined output reads 0.
- R3: An accepted operation with code 2'b10 (load) writes load_data[15:0] to low, load_data[31:16] to mid and load_data[39:32] to the 8-bit top register, and zeroes the second mid register.
- R4: The combined output always equals the top byte placed at bits 39:32, plus (mid + second mid) shifted left by 16, plus low, taken modulo 2^40. It is registered and shows the effect of an accepted operation right after the accepting clock edge.
- R5: For an accepted operation with code 2'b00 (multiply) and both half-selects 0, the product is opnd_a × opnd_b with both operands unsigned.
- R6: For a multiply where exactly one half-select is 1, the operand whose select is 1 is signed 16-bit and the other is unsigned. The result is the same whichever operand carries the signed half.
- R7: For a multiply with both half-selects 1, both operands are signed 16-bit.
- R8: A multiply stores its 40-bit sign-correct result by the same split as R3, so the second mid register is 0 after every multiply.
- R9: When op_valid is 0, or when the code is 2'b11, all partial registers and the combined output keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | 00 multiply, 01 clear, 10 load, 11 no operation |
| opnd_a | input | 16 | First multiplier operand |
| opnd_b | input | 16 | Second multiplier operand |
| sel_a_hi | input | 1 | opnd_a was taken from a high half (signed) |
| sel_b_hi | input | 1 | opnd_b was taken from a high half (signed) |
| load_data | input | 40 | Full product value for the load operation |
| prod_o | output | 40 | Registered combined product |
| part_lo | output | 16 | Low partial register |
| part_mid | output | 16 | Middle partial register |
| part_hi | output | 8 | Top partial register |
| part_mid2 | output | 16 | Second middle partial register |

## Verification
The checker runs on every cycle. It verifies that the combined output matches the sum of the four partial registers, that clear and load place the expected values in each part, that the product of each sign mode follows from the previous cycle's operands, and that idle cycles leave everything unchanged. Some behaviour can only be shown by the bench's scenarios. These are the reset preset, the carry of the redundant middle pair into the top byte, and results at the edges of each mode: an all-ones unsigned square, a mixed product with its operands swapped, and the most negative signed square. The bench also checks that a load whose top bit is set reads back as a negative value.

// File: rtl/prodreg_pkg.sv
package prodreg_pkg;

   typedef enum logic [1:0] {
      PR_MUL  = 2'b00,
      PR_CLR  = 2'b01,
      PR_LOAD = 2'b10,
      PR_NONE = 2'b11
   } pr_op_e;

   typedef enum logic [1:0] {
      SM_UU = 2'b00,
      SM_US = 2'b01,
      SM_SS = 2'b10
   } sign_mode_e;

endpackage

// File: rtl/prodreg_opsel.sv
module prodreg_opsel
   import prodreg_pkg::*;
#(
   parameter int OP_W = 16
) (
   input  logic [OP_W-1:0] opnd_a,
   input  logic [OP_W-1:0] opnd_b,
   input  logic            sel_a_hi,
   input  logic            sel_b_hi,
   output logic [OP_W-1:0] first_op,
   output logic [OP_W-1:0] second_op,
   output sign_mode_e      mode
);

   // The unsigned (low-half) operand always goes to the first slot.
   always_comb begin
      first_op  = opnd_a;
      second_op = opnd_b;
      unique case ({sel_a_hi, sel_b_hi})
         2'b00: mode = SM_UU;
         2'b11: mode = SM_SS;
         2'b01: mode = SM_US;
         default: begin
            mode      = SM_US;
            first_op  = opnd_b;
            second_op = opnd_a;
         end
      endcase
   end

endmodule

// File: rtl/prodreg_mult.sv
module prodreg_mult
   import prodreg_pkg::*;
#(
   parameter int OP_W   = 16,
   parameter int PROD_W = 40,
   parameter bit SHARED = 1'b1
) (
   input  logic [OP_W-1:0]   first_op,
   input  logic [OP_W-1:0]   second_op,
   input  sign_mode_e        mode,
   output logic [PROD_W-1:0] result
);

   localparam int EXT_W = OP_W + 1;
   localparam int MUL_W = 2 * EXT_W;

   logic signed [MUL_W-1:0] raw;

   generate
      if (SHARED) begin : g_shared
         // One signed (OP_W+1)-bit array; the extension bit sets signedness.
         logic signed [EXT_W-1:0] ext_f;
         logic signed [EXT_W-1:0] ext_s;
         always_comb begin
            ext_f = {(mode == SM_SS) & first_op[OP_W-1], first_op};
            ext_s = {(mode != SM_UU) & second_op[OP_W-1], second_op};
            raw   = ext_f * ext_s;
         end
      end else begin : g_split
         // Three dedicated arrays, one per sign mode, muxed at the output.
         logic signed [MUL_W-1:0] p_uu;
         logic signed [MUL_W-1:0] p_us;
         logic signed [MUL_W-1:0] p_ss;
         always_comb begin
            p_uu = MUL_W'(first_op) * MUL_W'(second_op);
            p_us = $signed({1'b0, first_op}) * $signed(second_op);
            p_ss = $signed(first_op) * $signed(second_op);
            unique case (mode)
               SM_UU:   raw = p_uu;
               SM_SS:   raw = p_ss;
               default: raw = p_us;
            endcase
         end
      end
   endgenerate

   assign result = {{(PROD_W-MUL_W){raw[MUL_W-1]}}, raw};

endmodule

// File: rtl/prodreg_combine.sv
module prodreg_combine #(
   parameter int OP_W   = 16,
   parameter int HI_W   = 8,
   parameter int PROD_W = 40
) (
   input  logic [OP_W-1:0]   lo,
   input  logic [OP_W-1:0]   mid,
   input  logic [HI_W-1:0]   hi,
   input  logic [OP_W-1:0]   mid2,
   output logic [PROD_W-1:0] sum
);

   localparam int TOP_LSB = 2 * OP_W;

   logic [OP_W:0]     mid_sum;
   logic [PROD_W-1:0] top_part;
   logic [PROD_W-1:0] mid_part;

   always_comb begin
      mid_sum  = {1'b0, mid} + {1'b0, mid2};
      top_part = {hi, {TOP_LSB{1'b0}}};
      mid_part = {{(PROD_W-OP_W-OP_W-1){1'b0}}, mid_sum, {OP_W{1'b0}}};
      sum      = top_part + mid_part + {{(PROD_W-OP_W){1'b0}}, lo};
   end

endmodule

// File: rtl/split_prod_mul.sv
module split_prod_mul
   import prodreg_pkg::*;
#(
   parameter int          OP_W      = 16,
   parameter int          HI_W      = 8,
   parameter int          PROD_W    = 2 * OP_W + HI_W,
   parameter logic [15:0] CLR_MID2  = 16'h0010,
   parameter bit          SHARED_MUL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [1:0]        op_code,
   input  logic [OP_W-1:0]   opnd_a,
   input  logic [OP_W-1:0]   opnd_b,
   input  logic              sel_a_hi,
   input  logic              sel_b_hi,
   input  logic [PROD_W-1:0] load_data,
   output logic [PROD_W-1:0] prod_o,
   output logic [OP_W-1:0]   part_lo,
   output logic [OP_W-1:0]   part_mid,
   output logic [HI_W-1:0]   part_hi,
   output logic [OP_W-1:0]   part_mid2
);

   localparam int          MID_LSB  = OP_W;
   localparam int          HI_LSB   = 2 * OP_W;
   localparam logic [OP_W-1:0] PRE_MID2 = OP_W'(CLR_MID2);
   localparam logic [OP_W-1:0] PRE_MID  = OP_W'(0) - PRE_MID2;
   localparam logic [HI_W-1:0] PRE_HI   = '1;
   localparam logic [OP_W-1:0] PRE_LO   = '0;

   generate
      if (PROD_W != 2 * OP_W + HI_W) begin : g_bad_width
         $error("split_prod_mul: PROD_W must equal 2*OP_W+HI_W");
      end
      if (HI_W < 2) begin : g_bad_hi
         $error("split_prod_mul: HI_W must hold the signed product overflow");
      end
      if (PRE_MID2 == '0) begin : g_bad_preset
         $error("split_prod_mul: CLR_MID2 must be non-zero to sum to zero");
      end
   endgenerate

   logic [OP_W-1:0]   first_op;
   logic [OP_W-1:0]   second_op;
   sign_mode_e        mode;
   logic [PROD_W-1:0] mul_res;

   prodreg_opsel #(.OP_W(OP_W)) u_opsel (
      .opnd_a    (opnd_a),
      .opnd_b    (opnd_b),
      .sel_a_hi  (sel_a_hi),
      .sel_b_hi  (sel_b_hi),
      .first_op  (first_op),
      .second_op (second_op),
      .mode      (mode)
   );

   prodreg_mult #(.OP_W(OP_W), .PROD_W(PROD_W), .SHARED(SHARED_MUL)) u_mult (
      .first_op  (first_op),
      .second_op (second_op),
      .mode      (mode),
      .result    (mul_res)
   );

   // Next state of the split register
   logic [OP_W-1:0]   lo_d, mid_d, mid2_d;
   logic [HI_W-1:0]   hi_d;
   logic [PROD_W-1:0] full_word;
   logic              do_split;
   logic [PROD_W-1:0] sum_d;

   always_comb begin
      lo_d      = part_lo;
      mid_d     = part_mid;
      hi_d      = part_hi;
      mid2_d    = part_mid2;
      do_split  = 1'b0;
      full_word = load_data;
      if (op_valid) begin
         unique case (pr_op_e'(op_code))
            PR_MUL:  begin do_split = 1'b1; full_word = mul_res; end
            PR_LOAD: begin do_split = 1'b1; full_word = load_data; end
            PR_CLR:  begin
               lo_d   = PRE_LO;
               mid_d  = PRE_MID;
               hi_d   = PRE_HI;
               mid2_d = PRE_MID2;
            end
            default: ;
         endcase
      end
      if (do_split) begin
         lo_d   = full_word[MID_LSB-1:0];
         mid_d  = full_word[HI_LSB-1:MID_LSB];
         hi_d   = full_word[PROD_W-1:HI_LSB];
         mid2_d = '0;
      end
   end

   prodreg_combine #(.OP_W(OP_W), .HI_W(HI_W), .PROD_W(PROD_W)) u_comb (
      .lo   (lo_d),
      .mid  (mid_d),
      .hi   (hi_d),
      .mid2 (mid2_d),
      .sum  (sum_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part_lo   <= PRE_LO;
         part_mid  <= PRE_MID;
         part_hi   <= PRE_HI;
         part_mid2 <= PRE_MID2;
         prod_o    <= '0;
      end else begin
         part_lo   <= lo_d;
         part_mid  <= mid_d;
         part_hi   <= hi_d;
         part_mid2 <= mid2_d;
         prod_o    <= sum_d;
      end
   end

endmodule

// File: rtl/split_prod_mul_chk.sv
module split_prod_mul_chk #(
   parameter int OP_W   = 16,
   parameter int HI_W   = 8,
   parameter int PROD_W = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [1:0]        op_code,
   input logic [OP_W-1:0]   opnd_a,
   input logic [OP_W-1:0]   opnd_b,
   input logic              sel_a_hi,
   input logic              sel_b_hi,
   input logic [PROD_W-1:0] load_data,
   input logic [PROD_W-1:0] prod_o,
   input logic [OP_W-1:0]   part_lo,
   input logic [OP_W-1:0]   part_mid,
   input logic [HI_W-1:0]   part_hi,
   input logic [OP_W-1:0]   part_mid2
);

   logic [PROD_W-1:0] chk_sum;
   logic [PROD_W-1:0] ref_mul;
   logic signed [PROD_W-1:0] ext_a, ext_b;

   always_comb begin
      chk_sum = (PROD_W'(part_hi) << (2 * OP_W))
              + ((PROD_W'(part_mid) + PROD_W'(part_mid2)) << OP_W)
              + PROD_W'(part_lo);
      ext_a   = sel_a_hi ? PROD_W'($signed(opnd_a)) : PROD_W'(opnd_a);
      ext_b   = sel_b_hi ? PROD_W'($signed(opnd_b)) : PROD_W'(opnd_b);
      ref_mul = ext_a * ext_b;
   end

   wire fire_mul = op_valid && op_code == 2'b00;
   wire fire_clr = op_valid && op_code == 2'b01;
   wire fire_ld  = op_valid && op_code == 2'b10;
   wire idle     = !op_valid || op_code == 2'b11;

   p_sum_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      prod_o == chk_sum);

   p_clear_preset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fire_clr |=> part_lo == '0 && part_mid == 16'hfff0 && part_hi == 8'hff
                   && part_mid2 == 16'h0010 && prod_o == '0);

   p_load_split_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fire_ld |=> {part_hi, part_mid, part_lo} == $past(load_data) && part_mid2 == '0);

   p_mul_uu_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_mul && !sel_a_hi && !sel_b_hi) |=> prod_o == $past(ref_mul));

   p_mul_mixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_mul && (sel_a_hi != sel_b_hi)) |=> prod_o == $past(ref_mul));

   p_mul_ss_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_mul && sel_a_hi && sel_b_hi) |=> prod_o == $past(ref_mul));

   p_mul_mid2_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fire_mul |=> part_mid2 == '0);

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> $stable(prod_o) && $stable(part_lo) && $stable(part_mid)
               && $stable(part_hi) && $stable(part_mid2));

endmodule

bind split_prod_mul split_prod_mul_chk #(.OP_W(OP_W), .HI_W(HI_W), .PROD_W(PROD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_code   (op_code),
   .opnd_a    (opnd_a),
   .opnd_b    (opnd_b),
   .sel_a_hi  (sel_a_hi),
   .sel_b_hi  (sel_b_hi),
   .load_data (load_data),
   .prod_o    (prod_o),
   .part_lo   (part_lo),
   .part_mid  (part_mid),
   .part_hi   (part_hi),
   .part_mid2 (part_mid2)
);

// File: tb/tb_split_prod_mul.sv
module tb_split_prod_mul;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_code = 2'b11;
   logic [15:0] opnd_a = '0, opnd_b = '0;
   logic        sel_a_hi = 1'b0, sel_b_hi = 1'b0;
   logic [39:0] load_data = '0;
   logic [39:0] prod_o;
   logic [15:0] part_lo, part_mid, part_mid2;
   logic [7:0]  part_hi;

   always #(CLK_P/2) clk = ~clk;

   split_prod_mul dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .sel_a_hi(sel_a_hi), .sel_b_hi(sel_b_hi),
      .load_data(load_data), .prod_o(prod_o), .part_lo(part_lo),
      .part_mid(part_mid), .part_hi(part_hi), .part_mid2(part_mid2)
   );

   int n_total = 0;
   int n_bad   = 0;
   bit finished = 0;

   // Expected item: {prod, hi, mid, mid2, lo}
   typedef struct packed {
      logic [39:0] prod;
      logic [7:0]  hi;
      logic [15:0] mid;
      logic [15:0] mid2;
      logic [15:0] lo;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   logic  tb_expect = 1'b0;

   // Bench model state
   logic [15:0] m_lo = 16'h0000, m_mid = 16'hfff0, m_mid2 = 16'h0010;
   logic [7:0]  m_hi = 8'hff;

   task automatic chk(string req, string what, logic [39:0] act, logic [39:0] exp);
      n_total++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [39:0] model_sum();
      longint p;
      p = (longint'($signed(m_hi)) <<< 32) + ((longint'(m_mid) + longint'(m_mid2)) << 16)
          + longint'(m_lo);
      return p[39:0];
   endfunction

   function automatic logic [39:0] model_mul(logic [15:0] a, logic [15:0] b, logic sa, logic sb);
      longint x, y, p;
      x = sa ? longint'($signed(a)) : longint'(a);
      y = sb ? longint'($signed(b)) : longint'(b);
      p = x * y;
      return p[39:0];
   endfunction

   // Driver: one operation per cycle, expected result pushed into the queue
   task automatic step(logic v, logic [1:0] code, logic [15:0] a, logic [15:0] b,
                       logic sa, logic sb, logic [39:0] ld, string req);
      logic [39:0] w;
      @(negedge clk);
      op_valid = v; op_code = code; opnd_a = a; opnd_b = b;
      sel_a_hi = sa; sel_b_hi = sb; load_data = ld; tb_expect = 1'b1;
      if (v && code == 2'b01) begin
         m_lo = 16'h0000; m_mid = 16'hfff0; m_hi = 8'hff; m_mid2 = 16'h0010;
      end else if (v && (code == 2'b00 || code == 2'b10)) begin
         w = (code == 2'b00) ? model_mul(a, b, sa, sb) : ld;
         m_lo = w[15:0]; m_mid = w[31:16]; m_hi = w[39:32]; m_mid2 = 16'h0000;
      end
      exp_q.push_back('{prod: model_sum(), hi: m_hi, mid: m_mid, mid2: m_mid2, lo: m_lo});
      tag_q.push_back(req);
   endtask

   // Monitor: compare shortly after each edge that took a driven step
   initial begin
      forever begin
         @(posedge clk);
         if (tb_expect) begin
            exp_t  e;
            string t;
            #(CLK_P/4);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, "prod", prod_o, e.prod);
            chk(t, "lo", 40'(part_lo), 40'(e.lo));
            chk(t, "mid", 40'(part_mid), 40'(e.mid));
            chk(t, "hi", 40'(part_hi), 40'(e.hi));
            chk(t, "mid2", 40'(part_mid2), 40'(e.mid2));
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", n_total, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_total++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      // R1: reset preset
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "reset lo", 40'(part_lo), 40'h0);
      chk("R1", "reset mid", 40'(part_mid), 40'hfff0);
      chk("R1", "reset hi", 40'(part_hi), 40'hff);
      chk("R1", "reset mid2", 40'(part_mid2), 40'h0010);
      chk("R1", "reset prod", prod_o, 40'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "after release prod", prod_o, 40'h0);

      step(1, 2'b10, 16'h0, 16'h0, 0, 0, 40'h12_3456_789a, "R3_R4_load");
      step(0, 2'b01, 16'h0, 16'h0, 0, 0, 40'h0, "R9_valid_low");
      step(1, 2'b11, 16'h1234, 16'h5678, 1, 1, 40'hff_ffff_ffff, "R9_code_none");
      step(1, 2'b01, 16'h0, 16'h0, 0, 0, 40'h0, "R2_clear");
      step(1, 2'b00, 16'hffff, 16'hffff, 0, 0, 40'h0, "R5_R8_uu_max");
      step(1, 2'b10, 16'h0, 16'h0, 0, 0, 40'h80_0000_0001, "R3_R4_load_neg");
      step(1, 2'b00, 16'hffff, 16'h8000, 0, 1, 40'h0, "R6_mixed_b_signed");
      step(1, 2'b00, 16'h8000, 16'hffff, 1, 0, 40'h0, "R6_mixed_a_signed");
      step(1, 2'b01, 16'h0, 16'h0, 0, 0, 40'h0, "R2_clear_again");
      step(1, 2'b00, 16'h8000, 16'h8000, 1, 1, 40'h0, "R7_ss_min");
      step(1, 2'b00, 16'hffff, 16'h0005, 1, 1, 40'h0, "R7_ss_neg");
      step(1, 2'b00, 16'h8000, 16'h0002, 0, 0, 40'h0, "R5_uu_top_bit");
      step(0, 2'b00, 16'h7fff, 16'h7fff, 1, 1, 40'h0, "R9_valid_low_mul");
      step(1, 2'b01, 16'h0, 16'h0, 0, 0, 40'h0, "R2_R4_clear_sum");
      @(negedge clk);
      op_valid = 1'b0;
      tb_expect = 1'b0;
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule